// File: doc/BRIEF.md
# Destination Contention Scheduler for a Three-Port Code-Spread Router

The block sits at the centre of a small router in which three attached cores share one summed channel. Each core spreads its data with a code chosen by its own address, and each receiver picks out a sender by correlating against that sender's code. Every cycle each port may offer a header that names where its next packet goes. The scheduler checks those headers, finds destinations that two ports want at the same moment, lets one of them through, and holds the other back for a later cycle.

For every port it produces a grant, which is also the one-cycle pop strobe for that port's input buffer. It also gives the address that drives the port's sending code generator (zero, the idle code, when the port is not granted) and the destination the port is sending to. For every destination it gives the source address that the receiver there must decode, or zero when nobody sends to it. A port granted in one cycle sits out the next arbitration while its buffer moves to the next packet. Because of this, a port that loses is served in the very next round if it keeps its request.

Top module: `dest_contention_sched`

## Requirements
- R1: While rst_ni is low, every output (grant_o, src_sel_o, dst_sel_o, dec_src_o) is zero.
- R2: A header is 4 bits, destination in bits [3:2] and source in bits [1:0], and port p (header bits [4p+3:4p]) has the fixed address p+1 (01, 10, 11). A request counts only if req_i[p] is high, the source field equals the port address, and the destination is neither 00 nor the port's own address. A request that does not count is never granted.
- R3: A counted, eligible request whose destination no other counted, eligible request names is always granted.
- R4: At most one port is granted per destination. When two eligible ports name the same destination, the one with the lower address wins.
- R5: A port granted in one round is not eligible in the following round. A port denied in a round, whose request and header stay unchanged, is therefore granted in the next round.
- R6: Outputs are registered. The decision on the inputs sampled at a rising clock edge appears just after that edge and lasts one cycle. grant_o[p] is the pop strobe of port p.
- R7: For the destination with address a, dec_src_o bits [2a-1:2a-2] hold the address of the granted source, or 00 (the idle code) when no port is granted to it.
- R8: src_sel_o bits [2p+1:2p] hold p+1 when port p is granted and 00 otherwise. dst_sel_o bits [2p+1:2p] hold the granted destination address and 00 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Per-port request |
| hdr_i | input | 12 | Per-port header, 4 bits each: destination [3:2], source [1:0] |
| grant_o | output | 3 | Per-port grant and buffer pop strobe |
| src_sel_o | output | 6 | Per-port address for the sending code generator, 00 when idle |
| dst_sel_o | output | 6 | Per-port granted destination address, 00 when idle |
| dec_src_o | output | 6 | Per-destination source address to decode, 00 when idle |

## Verification
Every combination of the three destination fields is applied under every request mask, each one from a clean state. This separates the no-contention outcome from contention at each of the three destinations, and it also covers headers that name the sender itself or address 00. Separate headers with a mismatched source field check that a malformed request is dropped rather than arbitrated. A contention held for several cycles shows the winner sitting out the next round and the loser being served in that round. This cannot be told apart from pure lowest-address priority in one cycle, but it can across consecutive cycles.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int unsigned SCH_ADDR_W = 2;
  localparam int unsigned SCH_PORTS  = (1 << SCH_ADDR_W) - 1;
endpackage

// File: rtl/sched_hdr_check.sv
module sched_hdr_check #(
  parameter int unsigned ADDR_W    = sched_pkg::SCH_ADDR_W,
  parameter int unsigned PORT_ADDR = 1
) (
  input  logic                  req_i,
  input  logic [2*ADDR_W-1:0]   hdr_i,
  input  logic                  busy_i,
  output logic                  cand_o,
  output logic [ADDR_W-1:0]     dst_o
);
  localparam logic [ADDR_W-1:0] OWN = ADDR_W'(PORT_ADDR);

  logic [ADDR_W-1:0] src;
  logic              fmt_ok;

  assign dst_o  = hdr_i[2*ADDR_W-1:ADDR_W];
  assign src    = hdr_i[ADDR_W-1:0];
  assign fmt_ok = (src == OWN) && (dst_o != '0) && (dst_o != OWN);
  // busy: port was granted last round, its buffer is advancing
  assign cand_o = req_i && fmt_ok && !busy_i;
endmodule

// File: rtl/sched_dest_arb.sv
module sched_dest_arb #(
  parameter int unsigned ADDR_W    = sched_pkg::SCH_ADDR_W,
  parameter int unsigned NUM_PORTS = sched_pkg::SCH_PORTS,
  parameter int unsigned DEST_ADDR = 1
) (
  input  logic [NUM_PORTS-1:0]        cand_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] dst_i,
  output logic [NUM_PORTS-1:0]        win_o,
  output logic [ADDR_W-1:0]           src_o
);
  localparam logic [ADDR_W-1:0] DEST = ADDR_W'(DEST_ADDR);

  logic [NUM_PORTS-1:0] hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
    assign hit[p] = cand_i[p] && (dst_i[p*ADDR_W +: ADDR_W] == DEST);
  end

  // lowest port index (lowest address) wins
  always_comb begin
    logic found;
    found = 1'b0;
    win_o = '0;
    src_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit[p] && !found) begin
        win_o[p] = 1'b1;
        src_o    = ADDR_W'(p + 1);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dest_contention_sched.sv
module dest_contention_sched #(
  parameter int unsigned ADDR_W = sched_pkg::SCH_ADDR_W,
  localparam int unsigned NUM_PORTS = (1 << ADDR_W) - 1,
  localparam int unsigned HDR_W     = 2 * ADDR_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        req_i,
  input  logic [NUM_PORTS*HDR_W-1:0]  hdr_i,
  output logic [NUM_PORTS-1:0]        grant_o,
  output logic [NUM_PORTS*ADDR_W-1:0] src_sel_o,
  output logic [NUM_PORTS*ADDR_W-1:0] dst_sel_o,
  output logic [NUM_PORTS*ADDR_W-1:0] dec_src_o
);
  logic [NUM_PORTS-1:0]        grant_q, cand, win;
  logic [NUM_PORTS*ADDR_W-1:0] dst_w, dec_d, src_sel_d, dst_sel_d;
  logic [NUM_PORTS*ADDR_W-1:0] src_sel_q, dst_sel_q, dec_q;
  logic [NUM_PORTS-1:0]        win_by_dest [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    sched_hdr_check #(.ADDR_W(ADDR_W), .PORT_ADDR(p + 1)) u_chk (
      .req_i  (req_i[p]),
      .hdr_i  (hdr_i[p*HDR_W +: HDR_W]),
      .busy_i (grant_q[p]),
      .cand_o (cand[p]),
      .dst_o  (dst_w[p*ADDR_W +: ADDR_W])
    );
  end

  for (genvar d = 0; d < NUM_PORTS; d++) begin : g_dest
    sched_dest_arb #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .DEST_ADDR(d + 1)) u_arb (
      .cand_i (cand),
      .dst_i  (dst_w),
      .win_o  (win_by_dest[d]),
      .src_o  (dec_d[d*ADDR_W +: ADDR_W])
    );
  end

  always_comb begin
    win = '0;
    for (int d = 0; d < NUM_PORTS; d++) win |= win_by_dest[d];
    for (int p = 0; p < NUM_PORTS; p++) begin
      src_sel_d[p*ADDR_W +: ADDR_W] = win[p] ? ADDR_W'(p + 1) : '0;
      dst_sel_d[p*ADDR_W +: ADDR_W] = win[p] ? dst_w[p*ADDR_W +: ADDR_W] : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q   <= '0;
      src_sel_q <= '0;
      dst_sel_q <= '0;
      dec_q     <= '0;
    end else begin
      grant_q   <= win;
      src_sel_q <= src_sel_d;
      dst_sel_q <= dst_sel_d;
      dec_q     <= dec_d;
    end
  end

  assign grant_o   = grant_q;
  assign src_sel_o = src_sel_q;
  assign dst_sel_o = dst_sel_q;
  assign dec_src_o = dec_q;

  // checks on registered outputs
  logic [NUM_PORTS-1:0] dst_hit_q [NUM_PORTS];
  always_comb begin
    for (int d = 0; d < NUM_PORTS; d++)
      for (int p = 0; p < NUM_PORTS; p++)
        dst_hit_q[d][p] = grant_q[p] && (dst_sel_q[p*ADDR_W +: ADDR_W] == ADDR_W'(d + 1));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    assert_no_repeat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_q[p] |=> !grant_q[p]);
    assert_invalid_no_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cand[p] |=> !grant_q[p]);
    assert_sel_fields_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_q[p] |-> (src_sel_q[p*ADDR_W +: ADDR_W] == ADDR_W'(p + 1))
                     && (dst_sel_q[p*ADDR_W +: ADDR_W] != '0));
    assert_idle_fields_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grant_q[p] |-> (src_sel_q[p*ADDR_W +: ADDR_W] == '0)
                      && (dst_sel_q[p*ADDR_W +: ADDR_W] == '0));
    if (NUM_PORTS == 3) begin : g_fair
      assert_denied_next_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cand[p] && !win[p]) ##1 (req_i[p] && (hdr_i[p*HDR_W +: HDR_W] == $past(hdr_i[p*HDR_W +: HDR_W])))
        |-> win[p]);
    end
  end

  for (genvar d = 0; d < NUM_PORTS; d++) begin : g_dest_chk
    assert_one_per_dest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(dst_hit_q[d]));
    assert_dec_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_q[d*ADDR_W +: ADDR_W] != '0) |-> dst_hit_q[d][int'(dec_q[d*ADDR_W +: ADDR_W]) - 1]);
    assert_dec_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_q[d*ADDR_W +: ADDR_W] == '0) |-> (dst_hit_q[d] == '0));
  end
endmodule

// File: tb/dest_contention_sched_tb_top.sv
module dest_contention_sched_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic [11:0] hdr = '0;
  logic [2:0]  grant;
  logic [5:0]  src_sel, dst_sel, dec_src;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dest_contention_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .hdr_i(hdr),
    .grant_o(grant), .src_sel_o(src_sel), .dst_sel_o(dst_sel), .dec_src_o(dec_src)
  );

  typedef struct {
    logic [2:0] g;
    logic [5:0] ss, ds, dec;
    logic [2:0] uniq;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  logic [2:0] mask_m = '0;

  function automatic logic [3:0] mk(input logic [1:0] dst, input logic [1:0] src);
    return {dst, src};
  endfunction

  function automatic exp_t model(input logic [2:0] rq, input logic [11:0] h,
                                 input logic [2:0] mask, input string tag);
    exp_t       e;
    logic [2:0] cand;
    logic [1:0] dst [3];
    e.g = '0; e.ss = '0; e.ds = '0; e.dec = '0; e.uniq = '0; e.tag = tag;
    for (int p = 0; p < 3; p++) begin
      dst[p]  = h[p*4+2 +: 2];
      cand[p] = rq[p] && (h[p*4 +: 2] == 2'(p + 1)) && (dst[p] != 2'd0)
                && (dst[p] != 2'(p + 1)) && !mask[p];
    end
    for (int d = 1; d <= 3; d++) begin
      bit taken = 1'b0;
      for (int p = 0; p < 3; p++) begin
        if (cand[p] && dst[p] == 2'(d) && !taken) begin
          taken = 1'b1;
          e.g[p] = 1'b1;
          e.ss[p*2 +: 2] = 2'(p + 1);
          e.ds[p*2 +: 2] = 2'(d);
          e.dec[(d-1)*2 +: 2] = 2'(p + 1);
        end
      end
    end
    for (int p = 0; p < 3; p++) begin
      bit shared = 1'b0;
      for (int q = 0; q < 3; q++)
        if (q != p && cand[q] && dst[q] == dst[p]) shared = 1'b1;
      e.uniq[p] = cand[p] && !shared;
    end
    return e;
  endfunction

  task automatic drive(input logic [2:0] rq, input logic [11:0] h, input string tag);
    exp_t e;
    @(negedge clk);
    req = rq;
    hdr = h;
    e = model(rq, h, mask_m, tag);
    mask_m = e.g;
    sb.push_back(e);
  endtask

  // monitor: one item per cycle, sampled 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        int   cnt;
        e = sb.pop_front();
        checks++;
        if (grant !== e.g || src_sel !== e.ss || dst_sel !== e.ds || dec_src !== e.dec) begin
          errors++;
          $display("FAIL %s: grant=%b src=%h dst=%h dec=%h expected grant=%b src=%h dst=%h dec=%h",
                   e.tag, grant, src_sel, dst_sel, dec_src, e.g, e.ss, e.ds, e.dec);
        end
        checks++;
        if ((grant & e.uniq) !== e.uniq) begin
          errors++;
          $display("FAIL R3: grant=%b expected unblocked=%b", grant, e.uniq);
        end
        for (int d = 1; d <= 3; d++) begin
          cnt = 0;
          for (int p = 0; p < 3; p++)
            if (grant[p] && dst_sel[p*2 +: 2] == 2'(d)) cnt++;
          checks++;
          if (cnt > 1) begin
            errors++;
            $display("FAIL R4: destination %0d granted %0d times, expected at most 1", d, cnt);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    checks++;
    if (grant !== 3'b0 || src_sel !== 6'b0 || dst_sel !== 6'b0 || dec_src !== 6'b0) begin
      errors++;
      $display("FAIL R1: grant=%b src=%h dst=%h dec=%h expected all zero",
               grant, src_sel, dst_sel, dec_src);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2: malformed headers are never granted
    drive(3'b001, {4'h0, 4'h0, mk(2'd2, 2'd2)}, "R2 src mismatch");
    drive(3'b000, 12'h0, "R2 idle");
    drive(3'b111, {mk(2'd0, 2'd3), mk(2'd2, 2'd2), mk(2'd1, 2'd1)}, "R2 dst zero/self");
    drive(3'b000, 12'h0, "R2 idle");

    // R5: held contention on destination 11 between ports 01 and 10
    for (int i = 0; i < 4; i++)
      drive(3'b011, {4'h0, mk(2'd3, 2'd2), mk(2'd3, 2'd1)}, "R5 held contention");
    drive(3'b000, 12'h0, "R5 idle");
    // R5: loser on destination 01 (port 11) served after port 10
    drive(3'b110, {mk(2'd1, 2'd3), mk(2'd1, 2'd2), 4'h0}, "R4 R5 dest 01");
    drive(3'b110, {mk(2'd1, 2'd3), mk(2'd1, 2'd2), 4'h0}, "R5 loser served");
    drive(3'b000, 12'h0, "R6 idle pop ends");

    // R3 R4 R6 R7 R8: every destination combination under every request mask
    for (int a0 = 0; a0 < 4; a0++)
      for (int a1 = 0; a1 < 4; a1++)
        for (int a2 = 0; a2 < 4; a2++)
          for (int r = 0; r < 8; r++) begin
            drive(3'(r), {mk(2'(a2), 2'd3), mk(2'(a1), 2'd2), mk(2'(a0), 2'd1)},
                  "R3 R4 R6 R7 R8 sweep");
            drive(3'b000, 12'h0, "R6 R7 idle");
          end

    @(negedge clk);
    req = '0;
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule